// File: doc/BRIEF.md
# Timer Event Interrupt Combiner

This block collects the event pulses of a pair of timer channels and turns them into one interrupt request per channel. Every channel keeps six sticky event flags (four compare matches, a counter overflow and a counter underflow) that the timer core sets with single-cycle pulses. It also keeps an enable register and a control register. The control register holds a 3-bit priority level and a read-only request bit. The request bit is never latched: it follows, cycle by cycle, whether any flag is set together with its enable. Software learns which source fired only by reading the flags, and clears each one itself. Answering the interrupt does not clear anything.

Towards the processor the block gates each channel's request with a global interrupt-enable input. It also compares the channel's level against the current processor priority level, and it drives every channel's level out for arbitration. Software reaches the registers through a plain single-cycle write port with a combinational read-data output. Each channel takes a 4-address window: status at offset 0, enable at offset 1 and control at offset 2. Channel `c` starts at address `4*c`.

Top module: `tirq_combiner`

## Requirements
- R1: After reset every status flag, every enable bit and every priority level reads 0, and `irq_req` and `irq_lvl` are all 0.
- R2: A pulse on event input `evt[6*c+b]` sets status bit b of channel c on that clock edge, with b = 0..3 for compare A..D, b = 4 for overflow and b = 5 for underflow. The flag stays set until software clears it.
- R3: The request bit of a channel, read at control bit 3, is 1 whenever some status bit and its enable are both 1. Enable bits 0..3 gate compare A..D. Enable bit 4 gates both the overflow flag and the underflow flag.
- R4: When every set flag has lost its flag or its enable, the request bit returns to 0 at once. No request is held.
- R5: The request bit stays 1 while any other enabled flag remains set, even after one source has been cleared.
- R6: Writing the status register clears each flag whose write bit is 0 and leaves each flag whose write bit is 1 unchanged. An event pulse in the same cycle as a clearing write leaves that flag set.
- R7: `irq_req[c]` is 1 only when the channel's request bit is 1, `glb_ie` is 1 and the channel level is strictly greater than `cpu_ipl`. Level 0 never requests.
- R8: Control bits 2:0 hold the channel level. They are written by software and appear on `irq_lvl[3*c+:3]`. Writes to control bit 3 have no effect.
- R9: The channels are independent: a write to or an event on one channel leaves the other channel's registers unchanged. Addresses outside the register windows read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| evt | input | 12 | Event pulses, six per channel |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address for both write and read |
| bus_wdata | input | 6 | Write data |
| bus_rdata | output | 6 | Read data for `bus_addr`, combinational |
| glb_ie | input | 1 | Global interrupt enable |
| cpu_ipl | input | 3 | Current processor priority level |
| irq_req | output | 2 | Gated request to the processor, one per channel |
| irq_lvl | output | 6 | Priority level of each channel |

## Verification
The bench sets the underflow flag while only the overflow enable is on. A design that gave underflow no enable, or a separate one, would never raise the request. It clears one of two enabled flags to confirm that the request stays up, and clears the last enabled flag to confirm that it drops. A latching design would keep requesting in that case. A clearing write is aimed at a flag in the same cycle as its event: a design where the clear wins would lose the event. The level comparison is probed at equality and one below, and at level 0, which catches a greater-or-equal compare.

// File: rtl/tirq_pkg.sv
package tirq_pkg;
  localparam int NUM_SRC  = 6;   // compare A..D, overflow, underflow
  localparam int EN_W     = 5;   // compare A..D, shared over/underflow
  localparam int LVL_W    = 3;
  localparam int DATA_W   = NUM_SRC;
  localparam int REQ_BIT  = 3;   // request bit position in control reg

  typedef enum logic [1:0] {
    REG_STAT = 2'd0,
    REG_EN   = 2'd1,
    REG_CTL  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tirq_rst_sync.sv
module tirq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/tirq_chan.sv
module tirq_chan
  import tirq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt,
  input  logic               wr_stat,
  input  logic               wr_en,
  input  logic               wr_ctl,
  input  logic [DATA_W-1:0]  wdata,
  output logic [NUM_SRC-1:0] flags,
  output logic [EN_W-1:0]    en,
  output logic [LVL_W-1:0]   lvl,
  output logic               pend
);
  logic [NUM_SRC-1:0] flags_q, flags_nxt, en_mask;
  logic [EN_W-1:0]    en_q, en_nxt;
  logic [LVL_W-1:0]   lvl_q, lvl_nxt;
  logic               stat_ce;

  // next state
  always_comb begin
    flags_nxt = flags_q;
    if (wr_stat) flags_nxt = flags_q & wdata[NUM_SRC-1:0];
    flags_nxt = flags_nxt | evt;           // hardware set wins
    stat_ce   = wr_stat | (|evt);
    en_nxt    = wr_en  ? wdata[EN_W-1:0]  : en_q;
    lvl_nxt   = wr_ctl ? wdata[LVL_W-1:0] : lvl_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      en_q    <= '0;
      lvl_q   <= '0;
    end else begin
      if (stat_ce) flags_q <= flags_nxt;
      if (wr_en)   en_q    <= en_nxt;
      if (wr_ctl)  lvl_q   <= lvl_nxt;
    end
  end

  // the top enable bit covers both overflow and underflow
  assign en_mask = {en_q[EN_W-1], en_q};
  assign pend    = |(flags_q & en_mask);
  assign flags   = flags_q;
  assign en      = en_q;
  assign lvl     = lvl_q;
endmodule

// File: rtl/tirq_gate.sv
module tirq_gate
  import tirq_pkg::*;
(
  input  logic             pend,
  input  logic             glb_ie,
  input  logic [LVL_W-1:0] lvl,
  input  logic [LVL_W-1:0] ipl,
  output logic             req
);
  always_comb req = pend & glb_ie & (lvl > ipl);
endmodule

// File: rtl/tirq_combiner.sv
module tirq_combiner
  import tirq_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_CH*NUM_SRC-1:0] evt,
  input  logic                      bus_we,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [DATA_W-1:0]         bus_wdata,
  output logic [DATA_W-1:0]         bus_rdata,
  input  logic                      glb_ie,
  input  logic [LVL_W-1:0]          cpu_ipl,
  output logic [NUM_CH-1:0]         irq_req,
  output logic [NUM_CH*LVL_W-1:0]   irq_lvl
);
  localparam int CH_W = ADDR_W - 2;

  logic                      rst_sync_n;
  logic [CH_W-1:0]           sel_ch;
  reg_sel_e                  sel_reg;
  logic [NUM_CH*NUM_SRC-1:0] flags_flat;
  logic [NUM_CH*EN_W-1:0]    en_flat;
  logic [NUM_CH-1:0]         pend;

  tirq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  assign sel_ch  = bus_addr[ADDR_W-1:2];
  assign sel_reg = reg_sel_e'(bus_addr[1:0]);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = bus_we && (sel_ch == CH_W'(c));

    tirq_chan u_chan (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .evt     (evt[c*NUM_SRC +: NUM_SRC]),
      .wr_stat (hit && sel_reg == REG_STAT),
      .wr_en   (hit && sel_reg == REG_EN),
      .wr_ctl  (hit && sel_reg == REG_CTL),
      .wdata   (bus_wdata),
      .flags   (flags_flat[c*NUM_SRC +: NUM_SRC]),
      .en      (en_flat[c*EN_W +: EN_W]),
      .lvl     (irq_lvl[c*LVL_W +: LVL_W]),
      .pend    (pend[c])
    );

    tirq_gate u_gate (
      .pend   (pend[c]),
      .glb_ie (glb_ie),
      .lvl    (irq_lvl[c*LVL_W +: LVL_W]),
      .ipl    (cpu_ipl),
      .req    (irq_req[c])
    );
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (sel_ch == CH_W'(c)) begin
        case (sel_reg)
          REG_STAT: bus_rdata = flags_flat[c*NUM_SRC +: NUM_SRC];
          REG_EN:   bus_rdata = DATA_W'(en_flat[c*EN_W +: EN_W]);
          REG_CTL:  begin
            bus_rdata                   = DATA_W'(irq_lvl[c*LVL_W +: LVL_W]);
            bus_rdata[REQ_BIT]          = pend[c];
          end
          default:  bus_rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/tirq_combiner_chk.sv
module tirq_combiner_chk
  import tirq_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      rst_sync_n,
  input logic [NUM_CH*NUM_SRC-1:0] evt,
  input logic                      bus_we,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic [DATA_W-1:0]         bus_wdata,
  input logic                      glb_ie,
  input logic [NUM_CH*NUM_SRC-1:0] flags_flat,
  input logic [NUM_CH-1:0]         pend,
  input logic [NUM_CH-1:0]         irq_req,
  input logic [NUM_CH*LVL_W-1:0]   irq_lvl
);
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_sync_n) |-> (flags_flat == '0 && irq_lvl == '0 && irq_req == '0)); // R1

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    AST_NO_PEND_NO_REQ: assert property (@(posedge clk) disable iff (!rst_sync_n)
      !pend[c] |-> !irq_req[c]); // R4
    AST_IE_MASKS: assert property (@(posedge clk) disable iff (!rst_sync_n)
      !glb_ie |-> !irq_req[c]); // R7
    AST_LVL_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (irq_lvl[c*LVL_W +: LVL_W] == '0) |-> !irq_req[c]); // R7
    AST_LVL_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
      !(bus_we && bus_addr == ADDR_W'(4*c + 2)) |=> $stable(irq_lvl[c*LVL_W +: LVL_W])); // R8
    for (genvar b = 0; b < NUM_SRC; b++) begin : g_b
      AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_sync_n)
        evt[c*NUM_SRC+b] |=> flags_flat[c*NUM_SRC+b]); // R2
      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (flags_flat[c*NUM_SRC+b] &&
         !(bus_we && bus_addr == ADDR_W'(4*c) && !bus_wdata[b]))
        |=> flags_flat[c*NUM_SRC+b]); // R6
    end
  end
endmodule

bind tirq_combiner tirq_combiner_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n), .evt(evt),
  .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .glb_ie(glb_ie), .flags_flat(flags_flat), .pend(pend),
  .irq_req(irq_req), .irq_lvl(irq_lvl)
);

// File: tb/tirq_combiner_test.sv
module tirq_combiner_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] evt;
  logic        bus_we;
  logic [3:0]  bus_addr;
  logic [5:0]  bus_wdata;
  logic [5:0]  bus_rdata;
  logic        glb_ie;
  logic [2:0]  cpu_ipl;
  logic [1:0]  irq_req;
  logic [5:0]  irq_lvl;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  tirq_combiner uut (
    .clk(clk), .rst_n(rst_n), .evt(evt), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .glb_ie(glb_ie),
    .cpu_ipl(cpu_ipl), .irq_req(irq_req), .irq_lvl(irq_lvl)
  );

  typedef struct packed {
    logic       we;
    logic [3:0] addr;
    logic [5:0] wd;
    logic [11:0] evt;
    logic       ie;
    logic [2:0] ipl;
    logic [3:0] raddr;
    logic [5:0] exp_rd;
    logic [1:0] exp_req;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 4'd2, 6'h0D, 12'h000, 1'b1, 3'd0, 4'd2, 6'h05, 2'b00, 4'd8}, // R8 bit3 ignored
    '{1'b1, 4'd1, 6'h01, 12'h000, 1'b1, 3'd0, 4'd1, 6'h01, 2'b00, 4'd3},
    '{1'b0, 4'd0, 6'h00, 12'h002, 1'b1, 3'd0, 4'd0, 6'h02, 2'b00, 4'd3}, // R3 unenabled B
    '{1'b0, 4'd0, 6'h00, 12'h001, 1'b1, 3'd0, 4'd2, 6'h0D, 2'b01, 4'd3}, // R3 A enabled
    '{1'b0, 4'd0, 6'h00, 12'h000, 1'b1, 3'd0, 4'd0, 6'h03, 2'b01, 4'd2}, // R2 sticky
    '{1'b1, 4'd0, 6'h3E, 12'h000, 1'b1, 3'd0, 4'd2, 6'h05, 2'b00, 4'd4}, // R4 drop
    '{1'b1, 4'd1, 6'h10, 12'h000, 1'b1, 3'd0, 4'd2, 6'h05, 2'b00, 4'd4},
    '{1'b0, 4'd0, 6'h00, 12'h020, 1'b1, 3'd0, 4'd2, 6'h0D, 2'b01, 4'd3}, // R3 udf shares enable
    '{1'b0, 4'd0, 6'h00, 12'h010, 1'b1, 3'd0, 4'd0, 6'h32, 2'b01, 4'd2},
    '{1'b1, 4'd0, 6'h2F, 12'h000, 1'b1, 3'd0, 4'd0, 6'h22, 2'b01, 4'd5}, // R5 stays
    '{1'b1, 4'd1, 6'h02, 12'h000, 1'b1, 3'd0, 4'd2, 6'h0D, 2'b01, 4'd5},
    '{1'b0, 4'd0, 6'h00, 12'h000, 1'b0, 3'd0, 4'd2, 6'h0D, 2'b00, 4'd7}, // R7 ie off
    '{1'b0, 4'd0, 6'h00, 12'h000, 1'b1, 3'd5, 4'd2, 6'h0D, 2'b00, 4'd7}, // R7 equal level
    '{1'b0, 4'd0, 6'h00, 12'h000, 1'b1, 3'd4, 4'd1, 6'h02, 2'b01, 4'd7}, // R7 one below
    '{1'b1, 4'd0, 6'h00, 12'h008, 1'b1, 3'd4, 4'd0, 6'h08, 2'b00, 4'd6}, // R6 set wins
    '{1'b1, 4'd6, 6'h07, 12'h000, 1'b1, 3'd4, 4'd6, 6'h07, 2'b00, 4'd8},
    '{1'b1, 4'd5, 6'h08, 12'h000, 1'b1, 3'd4, 4'd5, 6'h08, 2'b00, 4'd9},
    '{1'b0, 4'd0, 6'h00, 12'h204, 1'b1, 3'd4, 4'd4, 6'h08, 2'b10, 4'd9},
    '{1'b0, 4'd0, 6'h00, 12'h000, 1'b1, 3'd4, 4'd0, 6'h0C, 2'b10, 4'd9}, // R9 independent
    '{1'b0, 4'd0, 6'h00, 12'h000, 1'b1, 3'd4, 4'd3, 6'h00, 2'b10, 4'd9}, // R9 unmapped
    '{1'b1, 4'd4, 6'h3F, 12'h000, 1'b1, 3'd4, 4'd4, 6'h08, 2'b10, 4'd6}, // R6 write 1 keeps
    '{1'b1, 4'd1, 6'h08, 12'h000, 1'b1, 3'd4, 4'd2, 6'h0D, 2'b11, 4'd7}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [3:0] a, input logic [5:0] wd,
                      input logic [11:0] e, input logic [3:0] raddr);
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = wd; evt = e;
    @(posedge clk);
    #1;
    bus_we = 1'b0; evt = '0; bus_addr = raddr;
    #1;
  endtask

  task automatic read_at(input logic [3:0] a);
    @(negedge clk);
    bus_addr = a;
    #1;
  endtask

  initial begin
    rst_n = 1'b0; evt = '0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    glb_ie = 1'b1; cpu_ipl = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      read_at(4'(a));
      chk($sformatf("R1 reg %0d", a), 32'(bus_rdata), 32'h0);
    end
    chk("R1 irq_req", 32'(irq_req), 32'h0);
    chk("R1 irq_lvl", 32'(irq_lvl), 32'h0);

    for (int i = 0; i < NV; i++) begin
      glb_ie  = VECS[i].ie;
      cpu_ipl = VECS[i].ipl;
      step(VECS[i].we, VECS[i].addr, VECS[i].wd, VECS[i].evt, VECS[i].raddr);
      chk($sformatf("R%0d vec %0d rdata", VECS[i].rq, i), 32'(bus_rdata), 32'(VECS[i].exp_rd));
      chk($sformatf("R%0d vec %0d irq_req", VECS[i].rq, i), 32'(irq_req), 32'(VECS[i].exp_req));
    end
    // R8 level outputs
    chk("R8 irq_lvl", 32'(irq_lvl), 32'h3D);

    // R1 reset in the middle of operation
    @(negedge clk) rst_n = 1'b0;
    #1;
    chk("R1 irq_req in reset", 32'(irq_req), 32'h0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    for (int a = 0; a < 8; a++) begin
      read_at(4'(a));
      chk($sformatf("R1 reg %0d after reset", a), 32'(bus_rdata), 32'h0);
    end

    // R7 level 0 never requests
    glb_ie = 1'b1; cpu_ipl = 3'd0;
    step(1'b1, 4'd1, 6'h01, 12'h000, 4'd0);
    step(1'b0, 4'd0, 6'h00, 12'h001, 4'd2);
    chk("R7 level0 ctl", 32'(bus_rdata), 32'h08);
    chk("R7 level0 irq_req", 32'(irq_req), 32'h0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule